// File: doc/BRIEF.md
# Fairness-Interval Bus Arbiter with Urgent Class

This block is the central arbiter at the root of a tree-shaped shared bus. Up to 63 nodes raise a request line each. The arbiter hands the bus to exactly one of them with a one-hot grant. That grant stays in place until the owning node reports the end of its transfer on the done input. Each node has a fixed configuration, set by parameters: its hop depth from the root, its class (urgent or normal), and its ID, which is its port index.

Requests are served oldest first. Requests that appear in the same cycle are ordered by the shallowest depth first, then by the lowest ID. The bus runs in fairness intervals, each opened by a one-cycle start pulse. Within one interval a normal node can win the bus only once. Urgent nodes may win any number of times. However, after three urgent grants in a row, an eligible normal request takes the next grant, even if an older urgent request is waiting. When no eligible normal request is waiting, urgent nodes keep the bus busy.

The interface is a request/grant/done handshake rather than a stream. Back-pressure works as follows. A node keeps its request high until it is granted. The bus stays with it for as many cycles as it needs, until done is sampled high. A request that stays high after service counts as a new arrival. A node that drops its request before it is granted withdraws it.

Top module: `fair_bus_arbiter`

## Requirements
- R1: After reset, `grant_o` is all zero, every node's fairness flag is set and the urgent-run count is zero.
- R2: At most one bit of `grant_o` is set. With the bus idle, a request raised before clock edge k appears as a grant after edge k+1.
- R3: A grant stays unchanged until `done_i` is sampled high. At that edge `grant_o` clears, and the next grant can appear one edge later.
- R4: A request that arrived in an earlier cycle wins over one that arrived later, whatever their depths and IDs.
- R5: Requests that arrive in the same cycle are ordered by smaller depth first, then by lower node ID (port index).
- R6: Granting a normal node clears its fairness flag. While the flag is clear, the node's pending request is not granted, and it keeps its place in arrival order. A pulse on `interval_start_i` sets every flag again.
- R7: Urgent nodes ignore their fairness flag and can be granted several times within one interval.
- R8: The urgent-run count rises on each urgent grant, saturates at `URGENT_RATIO` (3), and returns to 0 on a normal grant. At the saturated count, an eligible normal request wins over any urgent request, older ones included.
- R9: With the count saturated and no eligible normal request pending, an urgent request is still granted.
- R10: A request held high through the end of its own transfer is treated as a new arrival, younger than every request already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | NODES | Per-node request level, bit i belongs to node ID i |
| done_i | input | 1 | Current owner ends its transfer |
| interval_start_i | input | 1 | One-cycle pulse opening a fairness interval |
| grant_o | output | NODES | One-hot bus grant |

## Verification
The bench builds the arbiter with six nodes. Nodes 0 to 2 are normal, at depths 2, 1 and 1. Nodes 3 to 5 are urgent, at depths 0, 0 and 1. The urgent ratio is 3. This configuration lets a same-cycle tie be decided by depth as well as by ID among the normal nodes. It also lets three urgent nodes rotate their re-arrivals so that the run count saturates while an older urgent request is still waiting. With that state reachable, the bench can check both the forced normal grant and the idle-avoidance grant at a saturated count. The bench also stalls normal nodes across an interval boundary, to check that a blocked request keeps its arrival order.

// File: rtl/fba_pkg.sv
package fba_pkg;

  // Static tie order for requests that arrived in the same cycle:
  // shallower depth wins, then the lower node index.
  function automatic logic tie_ahead(input int unsigned depth_a, input int unsigned depth_b,
                                     input int unsigned id_a, input int unsigned id_b);
    return (depth_a < depth_b) || ((depth_a == depth_b) && (id_a < id_b));
  endfunction

endpackage

// File: rtl/fba_age_matrix.sv
module fba_age_matrix #(
  parameter int NODES = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NODES-1:0]            req_i,
  input  logic [NODES-1:0]            served_i,
  output logic [NODES-1:0]            pend_o,
  output logic [NODES-1:0][NODES-1:0] older_o
);

  logic [NODES-1:0]            pend_q;
  logic [NODES-1:0][NODES-1:0] ord_q;
  logic [NODES-1:0]            arrive;
  logic [NODES-1:0]            stay;

  assign arrive = req_i & ~pend_q;
  assign stay   = pend_q & req_i & ~served_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      ord_q  <= '0;
    end else begin
      pend_q <= req_i & ~served_i;
      for (int j = 0; j < NODES; j++) begin
        if (arrive[j]) begin
          for (int i = 0; i < NODES; i++) begin
            ord_q[j][i] <= 1'b0;
            ord_q[i][j] <= (i != j) && stay[i];
          end
        end
      end
    end
  end

  assign pend_o  = pend_q;
  assign older_o = ord_q;

  logic order_clash;
  always_comb begin
    order_clash = 1'b0;
    for (int i = 0; i < NODES; i++)
      for (int j = 0; j < NODES; j++)
        if (pend_q[i] && pend_q[j] && ord_q[i][j] && ord_q[j][i]) order_clash = 1'b1;
  end

  // R4
  order_antisym_chk: assert property (@(posedge clk) disable iff (!rst_n) !order_clash);

endmodule

// File: rtl/fba_pick.sv
module fba_pick #(
  parameter int                       NODES      = 6,
  parameter int                       DEPTH_W    = 3,
  parameter logic [NODES*DEPTH_W-1:0] NODE_DEPTH = '0
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NODES-1:0]            pool_i,
  input  logic [NODES-1:0][NODES-1:0] older_i,
  output logic [NODES-1:0]            win_o
);

  import fba_pkg::*;

  always_comb begin
    for (int i = 0; i < NODES; i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < NODES; j++) begin
        if (j != i && pool_i[j]) begin
          if (older_i[j][i] ||
              (!older_i[i][j] &&
               tie_ahead(int'(NODE_DEPTH[j*DEPTH_W +: DEPTH_W]),
                         int'(NODE_DEPTH[i*DEPTH_W +: DEPTH_W]), j, i)))
            beaten = 1'b1;
        end
      end
      win_o[i] = pool_i[i] && !beaten;
    end
  end

  // R2
  pick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_o) && ((pool_i == '0) || (win_o != '0)));

endmodule

// File: rtl/fba_fair_ctl.sv
module fba_fair_ctl #(
  parameter int               NODES        = 6,
  parameter logic [NODES-1:0] NODE_URGENT  = '0,
  parameter int               URGENT_RATIO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             interval_start_i,
  input  logic [NODES-1:0] cand_i,
  input  logic             issue_i,
  input  logic [NODES-1:0] win_i,
  output logic [NODES-1:0] pool_o
);

  localparam int UCW = $clog2(URGENT_RATIO + 1);

  logic [NODES-1:0] en_q;
  logic [UCW-1:0]   urun_q;
  logic [NODES-1:0] elig;
  logic [NODES-1:0] norm_elig;
  logic             sat;
  logic             win_normal;

  assign elig       = cand_i & (NODE_URGENT | en_q);
  assign norm_elig  = elig & ~NODE_URGENT;
  assign sat        = (urun_q == UCW'(URGENT_RATIO));
  assign pool_o     = (sat && (norm_elig != '0)) ? norm_elig : elig;
  assign win_normal = (win_i & ~NODE_URGENT) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '1;
      urun_q <= '0;
    end else begin
      if (interval_start_i)
        en_q <= '1;
      else if (issue_i)
        en_q <= en_q & ~(win_i & ~NODE_URGENT);
      if (issue_i) begin
        if (win_normal)
          urun_q <= '0;
        else if (!sat)
          urun_q <= urun_q + 1'b1;
      end
    end
  end

  // R6
  fair_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |-> ((win_i & ~NODE_URGENT & ~en_q) == '0));

  // R8
  urgent_ratio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !win_normal && sat) |-> (norm_elig == '0));

  // R8
  urgent_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && win_normal) |=> (urun_q == '0));

endmodule

// File: rtl/fair_bus_arbiter.sv
module fair_bus_arbiter #(
  parameter int                       NODES        = 6,
  parameter int                       DEPTH_W      = 3,
  parameter logic [NODES*DEPTH_W-1:0] NODE_DEPTH   = {3'd1, 3'd0, 3'd0, 3'd1, 3'd1, 3'd2},
  parameter logic [NODES-1:0]         NODE_URGENT  = 6'b111000,
  parameter int                       URGENT_RATIO = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NODES-1:0] req_i,
  input  logic             done_i,
  input  logic             interval_start_i,
  output logic [NODES-1:0] grant_o
);

  logic [NODES-1:0]            grant_q;
  logic [NODES-1:0]            pend;
  logic [NODES-1:0][NODES-1:0] older;
  logic [NODES-1:0]            cand;
  logic [NODES-1:0]            pool;
  logic [NODES-1:0]            win;
  logic [NODES-1:0]            served;
  logic                        busy;
  logic                        issue;

  assign busy   = grant_q != '0;
  assign cand   = pend & req_i;
  assign issue  = !busy && (win != '0);
  assign served = grant_q & {NODES{done_i}};

  fba_age_matrix #(.NODES(NODES)) u_age (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .served_i(served),
    .pend_o(pend), .older_o(older)
  );

  fba_fair_ctl #(.NODES(NODES), .NODE_URGENT(NODE_URGENT), .URGENT_RATIO(URGENT_RATIO)) u_fair (
    .clk(clk), .rst_n(rst_n), .interval_start_i(interval_start_i),
    .cand_i(cand), .issue_i(issue), .win_i(win), .pool_o(pool)
  );

  fba_pick #(.NODES(NODES), .DEPTH_W(DEPTH_W), .NODE_DEPTH(NODE_DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n), .pool_i(pool), .older_i(older), .win_o(win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      grant_q <= '0;
    else if (busy && done_i)
      grant_q <= '0;
    else if (issue)
      grant_q <= win;
  end

  assign grant_o = grant_q;

  // R2
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant_o));

  // R3
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done_i) |=> $stable(grant_o));

  // R3
  grant_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && done_i) |=> (grant_o == '0));

endmodule

// File: tb/tb_fair_bus_arbiter.sv
module tb_fair_bus_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic         done = 1'b0;
  logic         istart = 1'b0;
  logic [N-1:0] grant;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fair_bus_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .interval_start_i(istart), .grant_o(grant)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_grant(input int idx, input string tag, output int lat);
    lat = 0;
    for (int n = 1; n <= 20; n++) begin
      tick();
      if (grant != '0) begin
        lat = n;
        break;
      end
    end
    check(grant == N'(1 << idx), tag, int'(grant), 1 << idx);
  endtask

  task automatic finish(input int idx, input logic keep);
    logic [N-1:0] held;
    held = grant;
    tick();
    check(grant == held, "R3 grant held", int'(grant), int'(held));
    done = 1'b1;
    if (!keep) req[idx] = 1'b0;
    tick();
    done = 1'b0;
    check(grant == '0, "R3 release on done", int'(grant), 0);
  endtask

  task automatic no_grant(input int cycles, input string tag);
    logic seen;
    seen = 1'b0;
    for (int n = 0; n < cycles; n++) begin
      tick();
      if (grant != '0) seen = 1'b1;
    end
    check(!seen, tag, int'(grant), 0);
  endtask

  task automatic pulse_start();
    istart = 1'b1;
    tick();
    istart = 1'b0;
  endtask

  task automatic t_reset();
    tick();
    check(grant == '0, "R1 grant idle after reset", int'(grant), 0);
  endtask

  task automatic t_tie();
    int lat;
    pulse_start();
    req[2:0] = 3'b111;
    wait_grant(1, "R5 tie depth first", lat);
    check(lat == 2, "R2 idle latency", lat, 2);
    finish(1, 1'b0);
    wait_grant(2, "R5 tie then lower ID", lat);
    finish(2, 1'b0);
    wait_grant(0, "R5 deepest last", lat);
    finish(0, 1'b0);
  endtask

  task automatic t_fcfs();
    int lat;
    pulse_start();
    req[2] = 1'b1;
    wait_grant(2, "R2 single grant", lat);
    check(lat == 2, "R2 idle latency", lat, 2);
    req[0] = 1'b1;
    tick();
    tick();
    req[1] = 1'b1;
    finish(2, 1'b0);
    wait_grant(0, "R4 older request first", lat);
    finish(0, 1'b0);
    wait_grant(1, "R4 younger request next", lat);
    finish(1, 1'b0);
  endtask

  task automatic t_fair();
    int lat;
    pulse_start();
    req[0] = 1'b1;
    wait_grant(0, "R6 first grant in interval", lat);
    finish(0, 1'b1);
    no_grant(10, "R6 flag blocks second grant");
    req[1] = 1'b1;
    wait_grant(1, "R6 other node still enabled", lat);
    finish(1, 1'b1);
    no_grant(5, "R6 both normal nodes blocked");
    pulse_start();
    wait_grant(0, "R6 R10 blocked request keeps order", lat);
    finish(0, 1'b0);
    wait_grant(1, "R6 second blocked node", lat);
    finish(1, 1'b0);
  endtask

  task automatic t_urgent();
    int lat;
    pulse_start();
    req[3] = 1'b1;
    wait_grant(3, "R7 urgent grant", lat);
    req[4] = 1'b1;
    req[5] = 1'b1;
    finish(3, 1'b1);
    wait_grant(4, "R10 re-request is younger", lat);
    finish(4, 1'b1);
    wait_grant(5, "R7 third urgent grant", lat);
    req[0] = 1'b1;
    finish(5, 1'b1);
    wait_grant(0, "R8 normal forced after three urgent", lat);
    finish(0, 1'b0);
    wait_grant(3, "R8 count reset after normal", lat);
    finish(3, 1'b1);
    wait_grant(4, "R7 urgent again", lat);
    finish(4, 1'b1);
    wait_grant(5, "R7 urgent again", lat);
    finish(5, 1'b1);
    wait_grant(3, "R9 urgent at saturated count", lat);
    req[4] = 1'b0;
    req[5] = 1'b0;
    finish(3, 1'b0);
    no_grant(4, "R3 bus idle after all drop");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_tie();
    t_fcfs();
    t_fair();
    t_urgent();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule